// File: doc/BRIEF.md
# Cascaded Lookup-Table Logic Cell with Serial Configuration

This block is a single programmable logic cell. Two 4-input lookup tables each take a nibble of the cell's nine logic inputs. Their two results, together with the ninth input, index a third, 3-input lookup table. The cell output is either that final table value taken straight through, or the same value captured by a flip-flop on the logic clock.

Every table bit and the output-mode bit sit in one 41-bit shift register, loaded one bit per rising edge of a dedicated configuration clock while a load-enable is high. The register's bits are the cell's control wires; there is no other configuration path. The bit at the far end of the register leaves the cell on a serial output, so several cells can share one configuration stream in a daisy chain. While loading is under way the cell output is forced low and the flip-flop is kept clear, so a half-loaded cell never drives a stray value.

Top module: `lut_cascade_cell`

## Requirements
- R1: On each rising edge of config_clk with config_enable high, the configuration register shifts by one position and config_data_in enters at position 0.
- R2: The 41-bit configuration word is {mode[40], final table[39:32], table B[31:16], table A[15:0]}; it is loaded most significant bit first, so the first bit shifted in ends at position 40.
- R3: config_data_out always shows position 40, so a word shifted through the cell emerges on config_data_out, most significant bit first, 41 shifts later.
- R4: With config_enable low, config_clk edges and config_data_in have no effect on the stored configuration or on the cell's function.
- R5: Each table output equals the table bit whose index is the table's input vector read as an unsigned number; table A is indexed by data_in[3:0], table B by data_in[7:4].
- R6: The final table is indexed by {data_in[8], table B output, table A output}, with data_in[8] as the most significant index bit.
- R7: With mode = 0 and config_enable low, cell_out follows the final table output combinationally.
- R8: With mode = 1 and config_enable low, cell_out shows the final table value captured at the most recent rising edge of clk.
- R9: While config_enable is high, cell_out is 0 and each rising clk edge clears the output flip-flop, so right after loading ends a registered-mode cell outputs 0 until the next clk edge.
- R10: A table whose bits at indices 0 to 3 are 0,1,1,0 (repeated, 16'h6666 for table A) yields the XOR of its two lowest inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| config_clk | input | 1 | Configuration shift clock |
| config_data_in | input | 1 | Serial configuration bit in |
| config_enable | input | 1 | High: shift configuration, hold logic output low |
| config_data_out | output | 1 | Last configuration bit, for chaining to the next cell |
| clk | input | 1 | Logic clock for the output flip-flop |
| data_in | input | 9 | Logic inputs: [3:0] table A, [7:4] table B, [8] final table |
| cell_out | output | 1 | Cell logic output |

## Verification
The assertions watch, on every edge, that a loading configuration edge moves the input bit into the register and the previous bit 39 to the serial output, that the register never moves while loading is off, that the flip-flop is clear after any clk edge taken during loading, and that it otherwise captures the final table value. Only the bench scenarios can show the bit-to-table mapping, the truth-table lookups under real configurations, the XOR programming, the daisy-chain readback of a full word, and the zero output seen in the window just after loading ends.

// File: rtl/lut_cascade_cell.sv
module lut_cascade_cell #(
  parameter int K = 4
) (
  input  logic           config_clk,
  input  logic           config_data_in,
  input  logic           config_enable,
  output logic           config_data_out,
  input  logic           clk,
  input  logic [2*K:0]   data_in,
  output logic           cell_out
);
  localparam int TBL   = 1 << K;
  localparam int CTBL  = 8;
  localparam int CHAIN = 2 * TBL + CTBL + 1;

  logic [CHAIN-1:0] chain_q;
  logic [1:0]       stage1;
  logic [CTBL-1:0]  ctab;
  logic [2:0]       cidx;
  logic             c_out;
  logic             mode;
  logic             ff_q;

  always_ff @(posedge config_clk)
    if (config_enable) chain_q <= {chain_q[CHAIN-2:0], config_data_in};

  assign config_data_out = chain_q[CHAIN-1];
  assign mode            = chain_q[CHAIN-1];

  for (genvar g = 0; g < 2; g++) begin : g_first
    logic [TBL-1:0] tab;
    assign tab       = chain_q[g*TBL +: TBL];
    assign stage1[g] = tab[data_in[g*K +: K]];
  end

  assign ctab  = chain_q[2*TBL +: CTBL];
  assign cidx  = {data_in[2*K], stage1[1], stage1[0]};
  assign c_out = ctab[cidx];

  always_ff @(posedge clk)
    if (config_enable) ff_q <= 1'b0;
    else               ff_q <= c_out;

  assign cell_out = config_enable ? 1'b0 : (mode ? ff_q : c_out);

  assert_shift_in_R1: assert property (@(posedge config_clk) disable iff (!config_enable)
    config_enable |=> chain_q[0] == $past(config_data_in));

  assert_daisy_R3: assert property (@(posedge config_clk) disable iff (!config_enable)
    config_enable |=> config_data_out == $past(chain_q[CHAIN-2]));

  assert_hold_R4: assert property (@(posedge config_clk) disable iff (config_enable)
    !config_enable |=> $stable(chain_q));

  assert_ff_clear_R9: assert property (@(posedge clk) disable iff (!config_enable)
    config_enable |=> ff_q == 1'b0);

  assert_ff_capture_R8: assert property (@(posedge clk) disable iff (config_enable)
    !config_enable |=> ff_q == $past(c_out));
endmodule

// File: tb/lut_cascade_cell_tb.sv
module lut_cascade_cell_tb_top;
  logic       clk = 1'b0;
  logic       config_clk = 1'b0;
  logic       cfg_run = 1'b0;
  logic       config_enable = 1'b1;
  logic       config_data_in = 1'b0;
  logic       config_data_out;
  logic [8:0] data_in = 9'h1FF;
  logic       cell_out;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  lut_cascade_cell dut_i (
    .config_clk(config_clk), .config_data_in(config_data_in),
    .config_enable(config_enable), .config_data_out(config_data_out),
    .clk(clk), .data_in(data_in), .cell_out(cell_out));

  always #5 clk = ~clk;
  always #5 config_clk = cfg_run ? ~config_clk : 1'b0;

  localparam logic [40:0] CFG_AND = {1'b0, 8'h88, 16'h8000, 16'h8000};
  localparam logic [40:0] CFG_XOR = {1'b0, 8'h96, 16'hFFFE, 16'h6666};
  localparam logic [40:0] CFG_SEL = {1'b0, 8'hCA, 16'h8000, 16'h0001};
  localparam logic [40:0] CFG_REG = {1'b1, 8'h88, 16'h8000, 16'h8000};

  localparam logic [50:0] VECS [0:13] = '{
    {CFG_AND, 9'h0FF, 1'b1}, {CFG_AND, 9'h0F7, 1'b0},
    {CFG_AND, 9'h1FF, 1'b1}, {CFG_AND, 9'h07F, 1'b0},
    {CFG_XOR, 9'h000, 1'b0}, {CFG_XOR, 9'h001, 1'b1},
    {CFG_XOR, 9'h003, 1'b0}, {CFG_XOR, 9'h010, 1'b1},
    {CFG_XOR, 9'h111, 1'b1}, {CFG_XOR, 9'h102, 1'b0},
    {CFG_SEL, 9'h000, 1'b1}, {CFG_SEL, 9'h001, 1'b0},
    {CFG_SEL, 9'h1F0, 1'b1}, {CFG_SEL, 9'h170, 1'b0}
  };

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic load_cfg(input logic [40:0] w);
    cfg_run = 1'b1;
    config_enable = 1'b1;
    for (int i = 40; i >= 0; i--) begin
      config_data_in = w[i];
      @(negedge clk);
    end
    config_enable = 1'b0;
    cfg_run = 1'b0;
  endtask

  task automatic read_cfg(output logic [40:0] got);
    cfg_run = 1'b1;
    config_enable = 1'b1;
    for (int i = 40; i >= 0; i--) begin
      got[i] = config_data_out;
      config_data_in = 1'b0;
      @(negedge clk);
    end
    config_enable = 1'b0;
    cfg_run = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [40:0] cur;
    logic [40:0] rb;
    cur = '1;
    @(negedge clk);
    @(negedge clk);
    #1 check(cell_out, 1'b0, "R9 reset state output low while enable high");

    for (int i = 0; i < 14; i++) begin
      if (VECS[i][50:10] !== cur) begin
        load_cfg(VECS[i][50:10]);
        cur = VECS[i][50:10];
      end
      data_in = VECS[i][9:1];
      #1 check(cell_out, VECS[i][0], $sformatf("R5 R6 R7 R10 vector %0d", i));
      @(negedge clk);
    end

    load_cfg(CFG_XOR);
    read_cfg(rb);
    checks++;
    if (rb !== CFG_XOR) begin
      errors++;
      $display("FAIL R1 R2 R3 readback: got %h expected %h", rb, CFG_XOR);
    end

    load_cfg(CFG_AND);
    cfg_run = 1'b1;
    for (int i = 0; i < 20; i++) begin
      config_data_in = i[0] ^ i[2];
      @(negedge clk);
    end
    cfg_run = 1'b0;
    data_in = 9'h0FF;
    #1 check(cell_out, 1'b1, "R4 function intact after ignored edges");
    @(negedge clk);
    read_cfg(rb);
    checks++;
    if (rb !== CFG_AND) begin
      errors++;
      $display("FAIL R4 config changed while disabled: got %h expected %h", rb, CFG_AND);
    end

    load_cfg(CFG_REG);
    data_in = 9'h0FF;
    #1 check(cell_out, 1'b0, "R9 registered output low before first clk edge");
    @(negedge clk);
    #1 check(cell_out, 1'b1, "R8 captured value after edge");
    data_in = 9'h0F7;
    #1 check(cell_out, 1'b1, "R8 output holds until edge");
    @(negedge clk);
    #1 check(cell_out, 1'b0, "R8 new value after edge");
    data_in = 9'h0FF;
    @(negedge clk);
    #1 check(cell_out, 1'b1, "R8 recaptured high");

    config_enable = 1'b1;
    #1 check(cell_out, 1'b0, "R9 output forced low while enable high");
    @(negedge clk);
    config_enable = 1'b0;
    #1 check(cell_out, 1'b0, "R9 flip-flop cleared by clk edge during enable");
    @(negedge clk);
    #1 check(cell_out, 1'b1, "R8 capture resumes after enable falls");

    finish_run();
  end
endmodule